// File: doc/BRIEF.md
# Coprocessor Mailbox Command Sequencer

This block runs commands on an embedded coprocessor through a simple host-port write/read master. For an ordinary command it first stores a software-interrupt number at a fixed coprocessor address. It then writes a block of fourteen parameter words to consecutive even addresses. Last, it rings the mailbox with an execute code. It then waits for the coprocessor to raise its mailbox-out flag, reads the reply word, and reports completion. If the flag never comes, a cycle-counting watchdog closes the command with a timeout error.

Two other command kinds exist. The first is a bare reset, which writes only a reset code to the mailbox. The second is a port-reset helper, which builds its own interrupt number and parameters from a port bit and an engine index. Commands run strictly one at a time: a new one is taken only after the previous one has signalled completion. The reply, its decoded acknowledge/negative flags and the timeout flag stay valid until the next command is accepted.

Top module: `mbx_cmd_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, `wr_valid`, `rd_valid`, `done` and `timed_out` are 0, and `reply`, `reply_ack` and `reply_nak` are 0.
- R2: For an execute command (`cmd_kind` 0), the first write is a memory write (`wr_mbx`=0) of `cmd_int_num` to address 0x01C2.
- R3: Next come 14 memory writes. Write i (i = 0..13) carries `cmd_params[16*i+15:16*i]` to address 0x01C4 + 2*i, in increasing i.
- R4: After the parameter writes, one mailbox write (`wr_mbx`=1, `wr_addr`=0) carries 0xCE01, for exactly 16 writes in all.
- R5: A reset command (`cmd_kind` 1) makes exactly one write: a mailbox write of 0xFA50 with no memory writes.
- R6: A port-reset command (`cmd_kind` 2) follows the R2–R4 pattern with interrupt number 0x0074. Parameter 0 is 50, parameter 1 is `cmd_port | (cmd_engine << 1)`, and all other parameters are 0.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_mbx`, `wr_addr` and `wr_data` hold their values. A write completes only on a cycle with both signals high.
- R8: After the mailbox write, the block raises `rd_valid` once `mbx_out_flag` is seen. On the cycle with `rd_valid && rd_ready` it captures `rd_data` into `reply`, with `reply_ack` = (reply == 0x0FED) and `reply_nak` = (reply == 0xDEAD). `done` then pulses for one cycle.
- R9: The watchdog starts when the mailbox write completes. If `mbx_out_flag` is not high in any of the next `TIMEOUT_CYCLES` cycles, `done` pulses with `timed_out`=1 and `reply`=0, and no read is made. A flag seen in the last of those cycles still produces a normal reply.
- R10: `cmd_ready` is low from the accepting cycle until `done` is raised. While it is low, `cmd_valid` and the command inputs have no effect.
- R11: Accepting a command clears `reply`, `reply_ack`, `reply_nak` and `timed_out`. These values then stay unchanged after completion until the next command is accepted.
- R12: `cmd_kind` 3 behaves exactly like `cmd_kind` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle, command taken when both high |
| cmd_kind | input | 2 | 0/3 execute, 1 reset, 2 port reset |
| cmd_int_num | input | DATA_W | Software-interrupt number for execute |
| cmd_params | input | NUM_PARAMS*DATA_W | Parameter words, word i at bits [DATA_W*i +: DATA_W] |
| cmd_port | input | 1 | Port bit for port reset |
| cmd_engine | input | ENG_W | Engine index for port reset |
| wr_valid | output | 1 | Write request to host port |
| wr_ready | input | 1 | Host port accepts the write |
| wr_mbx | output | 1 | 1: mailbox write, 0: memory write |
| wr_addr | output | ADDR_W | Memory address (0 for mailbox) |
| wr_data | output | DATA_W | Write data |
| mbx_out_flag | input | 1 | Coprocessor has a reply in the mailbox |
| rd_valid | output | 1 | Mailbox read request |
| rd_ready | input | 1 | Mailbox read data valid this cycle |
| rd_data | input | DATA_W | Mailbox read data |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Last command ended without reply |
| reply | output | DATA_W | Captured reply word |
| reply_ack | output | 1 | Reply was the acknowledge code |
| reply_nak | output | 1 | Reply was the negative code |

## Verification
The checker assumes the host port keeps `wr_ready` and `rd_ready` as free handshakes that may stall for any number of cycles. It also assumes the coprocessor leaves `mbx_out_flag` high until its mailbox has been read. The bench drives both ready lines from fixed stall patterns and raises the flag only a chosen number of cycles after the logged mailbox write. It lowers the flag on the read handshake. In the late-flag timeout case it clears the stale flag before the next command starts.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;

  typedef enum logic [1:0] {
    KIND_EXEC     = 2'd0,
    KIND_RESET    = 2'd1,
    KIND_PORT_RST = 2'd2,
    KIND_EXEC_ALT = 2'd3
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTNUM,
    ST_PARAM,
    ST_DOOR,
    ST_WAIT,
    ST_READ
  } seq_state_e;

endpackage

// File: rtl/mbx_param_store.sv
module mbx_param_store #(
  parameter int DATA_W        = 16,
  parameter int NUM_PARAMS    = 14,
  parameter int ENG_W         = 1,
  parameter int PORT_RESET_MS = 50,
  localparam int IDX_W        = (NUM_PARAMS > 1) ? $clog2(NUM_PARAMS) : 1
) (
  input  logic                         clk,
  input  logic                         load,
  input  logic                         use_preset,
  input  logic [NUM_PARAMS*DATA_W-1:0] params_flat,
  input  logic                         port,
  input  logic [ENG_W-1:0]             engine,
  input  logic [IDX_W-1:0]             idx,
  output logic [DATA_W-1:0]            word_o
);

  logic [DATA_W-1:0] preset [NUM_PARAMS];
  logic [DATA_W-1:0] store  [NUM_PARAMS];

  // Built-in block for the port-reset helper: duration, selector, zeros.
  for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_preset
    if (g == 0) begin : g_dur
      assign preset[g] = DATA_W'(PORT_RESET_MS);
    end else if (g == 1) begin : g_sel
      assign preset[g] = DATA_W'({engine, port});
    end else begin : g_zero
      assign preset[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < NUM_PARAMS; i++) begin
        store[i] <= use_preset ? preset[i] : params_flat[i*DATA_W +: DATA_W];
      end
    end
  end

  assign word_o = store[idx];

endmodule

// File: rtl/mbx_timeout.sv
module mbx_timeout #(
  parameter int LIMIT = 240_000_000,
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = run && (cnt == LAST);

endmodule

// File: rtl/mbx_cmd_seq.sv
module mbx_cmd_seq
  import mbx_seq_pkg::*;
#(
  parameter int          DATA_W         = 16,
  parameter int          ADDR_W         = 16,
  parameter int          NUM_PARAMS     = 14,
  parameter int          ENG_W          = 1,
  parameter int          INT_NUM_ADDR   = 'h01C2,
  parameter int          PARAM_BASE     = 'h01C4,
  parameter int          PARAM_STRIDE   = 2,
  parameter int          EXEC_CODE      = 'hCE01,
  parameter int          RESET_CODE     = 'hFA50,
  parameter int          ACK_CODE       = 'h0FED,
  parameter int          NAK_CODE       = 'hDEAD,
  parameter int          PORT_RESET_INT = 'h0074,
  parameter int          PORT_RESET_MS  = 50,
  parameter int          TIMEOUT_CYCLES = 240_000_000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [1:0]                   cmd_kind,
  input  logic [DATA_W-1:0]            cmd_int_num,
  input  logic [NUM_PARAMS*DATA_W-1:0] cmd_params,
  input  logic                         cmd_port,
  input  logic [ENG_W-1:0]             cmd_engine,
  output logic                         wr_valid,
  input  logic                         wr_ready,
  output logic                         wr_mbx,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [DATA_W-1:0]            wr_data,
  input  logic                         mbx_out_flag,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  input  logic [DATA_W-1:0]            rd_data,
  output logic                         done,
  output logic                         timed_out,
  output logic [DATA_W-1:0]            reply,
  output logic                         reply_ack,
  output logic                         reply_nak
);

  localparam int IDX_W = (NUM_PARAMS > 1) ? $clog2(NUM_PARAMS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PARAMS - 1);

  seq_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              is_reset_q;
  logic [DATA_W-1:0] intnum_q;
  logic [DATA_W-1:0] param_word;
  logic              tmo_expired;
  logic              accept;
  logic              port_rst_cmd;

  assign cmd_ready    = (state == ST_IDLE);
  assign accept       = cmd_valid && cmd_ready;
  assign port_rst_cmd = (cmd_kind == KIND_PORT_RST);

  mbx_param_store #(
    .DATA_W(DATA_W), .NUM_PARAMS(NUM_PARAMS), .ENG_W(ENG_W),
    .PORT_RESET_MS(PORT_RESET_MS)
  ) u_store (
    .clk(clk), .load(accept), .use_preset(port_rst_cmd),
    .params_flat(cmd_params), .port(cmd_port), .engine(cmd_engine),
    .idx(idx), .word_o(param_word)
  );

  mbx_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
    .clk(clk), .rst(rst),
    .clr(state == ST_DOOR && wr_ready),
    .run(state == ST_WAIT),
    .expired(tmo_expired)
  );

  // Host-port request decode from the registered state.
  always_comb begin
    wr_valid = 1'b0;
    wr_mbx   = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    case (state)
      ST_INTNUM: begin
        wr_valid = 1'b1;
        wr_addr  = ADDR_W'(INT_NUM_ADDR);
        wr_data  = intnum_q;
      end
      ST_PARAM: begin
        wr_valid = 1'b1;
        wr_addr  = ADDR_W'(PARAM_BASE + int'(idx) * PARAM_STRIDE);
        wr_data  = param_word;
      end
      ST_DOOR: begin
        wr_valid = 1'b1;
        wr_mbx   = 1'b1;
        wr_data  = is_reset_q ? DATA_W'(RESET_CODE) : DATA_W'(EXEC_CODE);
      end
      default: ;
    endcase
  end

  assign rd_valid = (state == ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      is_reset_q <= 1'b0;
      intnum_q   <= '0;
      done       <= 1'b0;
      timed_out  <= 1'b0;
      reply      <= '0;
      reply_ack  <= 1'b0;
      reply_nak  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          timed_out  <= 1'b0;
          reply      <= '0;
          reply_ack  <= 1'b0;
          reply_nak  <= 1'b0;
          idx        <= '0;
          is_reset_q <= (cmd_kind == KIND_RESET);
          intnum_q   <= port_rst_cmd ? DATA_W'(PORT_RESET_INT) : cmd_int_num;
          state      <= (cmd_kind == KIND_RESET) ? ST_DOOR : ST_INTNUM;
        end
        ST_INTNUM: if (wr_ready) state <= ST_PARAM;
        ST_PARAM: if (wr_ready) begin
          if (idx == LAST_IDX) state <= ST_DOOR;
          else idx <= idx + 1'b1;
        end
        ST_DOOR: if (wr_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (mbx_out_flag) begin
            state <= ST_READ;
          end else if (tmo_expired) begin
            timed_out <= 1'b1;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_READ: if (rd_ready) begin
          reply     <= rd_data;
          reply_ack <= (rd_data == DATA_W'(ACK_CODE));
          reply_nak <= (rd_data == DATA_W'(NAK_CODE));
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mbx_cmd_seq_chk.sv
module mbx_cmd_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_mbx,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              done,
  input logic              timed_out,
  input logic [DATA_W-1:0] reply,
  input logic              reply_ack,
  input logic              reply_nak
);

  a_r10_one_activity: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_ready, wr_valid, rd_valid}));

  a_r7_write_held: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_mbx) && $stable(wr_addr) && $stable(wr_data));

  a_r8_done_after_read: assert property (@(posedge clk) disable iff (rst)
    done && !timed_out |-> $past(rd_valid && rd_ready));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_ready_on_done: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready);

  a_r9_timeout_empty: assert property (@(posedge clk) disable iff (rst)
    timed_out |-> reply == '0 && !reply_ack && !reply_nak);

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
    cmd_ready && !cmd_valid |=> $stable(reply) && $stable(timed_out) && $stable(reply_ack));

endmodule

bind mbx_cmd_seq mbx_cmd_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_mbx(wr_mbx),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .done(done), .timed_out(timed_out),
  .reply(reply), .reply_ack(reply_ack), .reply_nak(reply_nak)
);

// File: tb/mbx_cmd_seq_bench.sv
`timescale 1ns/100ps
module mbx_cmd_seq_bench;
  localparam int DW = 16, AW = 16, NP = 14, EW = 1, TMO = 20;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic           cmd_valid = 0, cmd_ready, cmd_port = 0;
  logic [1:0]     cmd_kind = 0;
  logic [DW-1:0]  cmd_int_num = 0;
  logic [NP*DW-1:0] cmd_params = '0;
  logic [EW-1:0]  cmd_engine = 0;
  logic           wr_valid, wr_ready = 1, wr_mbx;
  logic [AW-1:0]  wr_addr;
  logic [DW-1:0]  wr_data;
  logic           mbx_out_flag = 0, rd_valid, rd_ready = 1;
  logic [DW-1:0]  rd_data = 0;
  logic           done, timed_out, reply_ack, reply_nak;
  logic [DW-1:0]  reply;

  mbx_cmd_seq #(.TIMEOUT_CYCLES(TMO)) u_mbx_cmd_seq (.*);

  int total = 0, bad = 0, cyc = 0, stall = 0, flag_delay = 0;
  bit flag_arm = 0, finished = 0;
  logic [AW-1:0] lg_addr [64];
  logic [DW-1:0] lg_data [64];
  bit            lg_mbx  [64];
  int lg_n = 0, door_cyc = -1000, done_cnt = 0, done_cyc = 0, rd_cnt = 0;

  // Host-port and coprocessor model, all activity at the falling edge.
  always @(negedge clk) begin
    cyc++;
    wr_ready = (stall != 0) ? ((cyc % 3) != 0) : 1'b1;
    rd_ready = (stall != 0) ? ((cyc % 2) == 0) : 1'b1;
    if (!rst) begin
      if (wr_valid && wr_ready) begin
        if (lg_n < 64) begin
          lg_addr[lg_n] = wr_addr; lg_data[lg_n] = wr_data; lg_mbx[lg_n] = wr_mbx;
        end
        lg_n++;
        if (wr_mbx) door_cyc = cyc;
      end
      if (flag_arm && door_cyc >= 0 && cyc == door_cyc + flag_delay) mbx_out_flag = 1'b1;
      if (rd_valid && rd_ready) begin rd_cnt++; mbx_out_flag = 1'b0; end
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] kind, input logic [DW-1:0] intn, input logic [NP*DW-1:0] prm,
                     input logic port, input logic [EW-1:0] eng, input int dly, input bit arm,
                     input logic [DW-1:0] rv, input bit hold_valid);
    int d0;
    @(negedge clk); #1;
    lg_n = 0; door_cyc = -1000; rd_cnt = 0; mbx_out_flag = 0;
    flag_arm = arm; flag_delay = dly; rd_data = rv;
    d0 = done_cnt;
    cmd_kind = kind; cmd_int_num = intn; cmd_params = prm; cmd_port = port; cmd_engine = eng;
    cmd_valid = 1;
    @(negedge clk); #1;
    if (hold_valid) begin cmd_kind = ~kind; cmd_int_num = ~intn; end
    else cmd_valid = 0;
    chk(cmd_ready == 0 && timed_out == 0 && reply == 0 && !reply_ack, "R11 cleared on accept",
        {cmd_ready, timed_out, reply_ack, reply}, 0);
    while (done_cnt == d0) begin @(negedge clk); #1; end
    cmd_valid = 0;
  endtask

  task automatic check_writes(input logic [1:0] kind, input logic [DW-1:0] intn, input logic [NP*DW-1:0] prm,
                              input logic port, input logic [EW-1:0] eng, input string tag);
    logic [AW-1:0] ea [16];
    logic [DW-1:0] ed [16];
    bit            em [16];
    int n;
    if (kind == 2'd1) begin
      ea[0] = 0; ed[0] = 16'hFA50; em[0] = 1; n = 1;
    end else begin
      ea[0] = 16'h01C2; ed[0] = (kind == 2'd2) ? 16'h0074 : intn; em[0] = 0;
      for (int i = 0; i < NP; i++) begin
        ea[i+1] = AW'(16'h01C4 + 2 * i); em[i+1] = 0;
        if (kind == 2'd2) ed[i+1] = (i == 0) ? 16'd50 : (i == 1) ? DW'({eng, port}) : 16'h0;
        else ed[i+1] = prm[i*DW +: DW];
      end
      ea[15] = 0; ed[15] = 16'hCE01; em[15] = 1; n = 16;
    end
    chk(lg_n == n, {tag, " write count"}, lg_n, n);
    for (int i = 0; i < n && i < lg_n; i++)
      chk(lg_addr[i] == ea[i] && lg_data[i] == ed[i] && lg_mbx[i] == em[i], tag,
          {lg_mbx[i], lg_addr[i][14:0], lg_data[i]}, {em[i], ea[i][14:0], ed[i]});
  endtask

  task automatic check_reply(input logic [DW-1:0] rv, input string tag);
    chk(reply == rv && timed_out == 0, {tag, " reply"}, {timed_out, reply}, {1'b0, rv});
    chk(reply_ack == (rv == 16'h0FED) && reply_nak == (rv == 16'hDEAD), {tag, " decode"},
        {reply_ack, reply_nak}, {rv == 16'h0FED, rv == 16'hDEAD});
    chk(rd_cnt == 1, {tag, " one mailbox read"}, rd_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP*DW-1:0] p;
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    // R1: reset state
    chk(cmd_ready && !wr_valid && !rd_valid && !done, "R1 handshakes", {cmd_ready, wr_valid, rd_valid, done}, 4'b1000);
    chk(!timed_out && reply == 0 && !reply_ack && !reply_nak, "R1 results", {timed_out, reply_ack, reply_nak, reply}, 0);

    // R2 R3 R4 R7 R8: execute sweep, with and without host stalls
    for (int s = 0; s < 2; s++) begin
      for (int seed = 0; seed < 4; seed++) begin
        stall = s;
        for (int i = 0; i < NP; i++) p[i*DW +: DW] = DW'(seed * 16'h1357 + i * 16'h0101) ^ 16'hA5A5;
        run(2'd0, DW'(16'h0070 + seed), p, 0, 0, 1 + seed * 3, 1, 16'h0FED, 0);
        check_writes(2'd0, DW'(16'h0070 + seed), p, 0, 0, s ? "R7 stalled R3" : "R2 R3 R4");
        check_reply(16'h0FED, "R8");
        if (s == 0) chk(done_cyc - door_cyc == 1 + seed * 3 + 2, "R8 latency", done_cyc - door_cyc, 1 + seed * 3 + 2);
      end
    end
    stall = 0;

    // R12: kind 3 is an execute
    p = {NP{16'h3C5A}};
    run(2'd3, 16'h0099, p, 0, 0, 2, 1, 16'h0FED, 0);
    check_writes(2'd0, 16'h0099, p, 0, 0, "R12");

    // R5: bare reset, plain and stalled
    for (int s = 0; s < 2; s++) begin
      stall = s;
      run(2'd1, 16'h1111, p, 0, 0, 4, 1, 16'h0FED, 0);
      check_writes(2'd1, 0, p, 0, 0, "R5");
      check_reply(16'h0FED, "R5");
    end
    stall = 0;

    // R6: port reset for every port / engine pair
    for (int port = 0; port < 2; port++)
      for (int eng = 0; eng < 2; eng++) begin
        run(2'd2, 16'hBEEF, {NP{16'hFFFF}}, port[0], EW'(eng), 2, 1, 16'h0FED, 0);
        check_writes(2'd2, 0, 0, port[0], EW'(eng), "R6");
      end

    // R8 R11: negative reply, held across idle cycles
    run(2'd0, 16'h0072, p, 0, 0, 5, 1, 16'hDEAD, 0);
    check_reply(16'hDEAD, "R8 nak");
    repeat (6) @(negedge clk);
    #1;
    chk(reply == 16'hDEAD && reply_nak && !timed_out, "R11 held", {reply_nak, reply}, {1'b1, 16'hDEAD});

    // R10: cmd_valid left high while busy is ignored
    run(2'd0, 16'h0042, p, 0, 0, 3, 1, 16'h1234, 1);
    check_writes(2'd0, 16'h0042, p, 0, 0, "R10");
    check_reply(16'h1234, "R10");
    repeat (3) @(negedge clk);
    #1;
    chk(lg_n == 16 && cmd_ready, "R10 no extra command", lg_n, 16);

    // R9: no reply at all
    run(2'd0, 16'h0073, p, 0, 0, 0, 0, 16'h0FED, 0);
    chk(timed_out && reply == 0 && !reply_ack, "R9 timeout", {timed_out, reply}, {1'b1, 16'h0});
    chk(done_cyc - door_cyc == TMO + 1, "R9 timeout latency", done_cyc - door_cyc, TMO + 1);
    chk(rd_cnt == 0, "R9 no read", rd_cnt, 0);

    // R9: flag in the last watched cycle wins
    run(2'd0, 16'h0073, p, 0, 0, TMO, 1, 16'h0FED, 0);
    check_reply(16'h0FED, "R9 deadline");

    // R9: flag one cycle late is too late
    run(2'd0, 16'h0073, p, 0, 0, TMO + 1, 1, 16'h0FED, 0);
    chk(timed_out && reply == 0, "R9 late flag", {timed_out, reply}, {1'b1, 16'h0});
    repeat (4) @(negedge clk);
    #1;
    chk(rd_cnt == 0 && !rd_valid && timed_out, "R9 stale flag not read", rd_cnt, 0);
    mbx_out_flag = 0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule